// File: doc/BRIEF.md
# Halt-State Opcode Fetch Sequencer

This block is the control sequencer an 8-bit processor core uses while it is halted. When the core reports that it has executed a halt opcode, the block does not freeze the bus. It keeps running ordinary four-state opcode-fetch machine cycles at the address that follows the halt opcode. The first two states of each cycle drive the fetch, memory-request and read strobes. The last two states drive the memory-request and refresh strobes, with the refresh counter on the address bus.

Whatever byte memory returns during a halted fetch is discarded, and a no-operation code goes to the instruction decoder in its place. Altered memory contents therefore cannot wake the core. Interrupt lines are looked at only on the clock edge that ends the fourth state of a fetch, so a request that arrives mid-cycle waits for that cycle to finish.

When the block leaves the halt, it raises the halt line again and, in the same cycle, gives the core a one-cycle code for the cause: maskable, non-maskable or reset.

Top module: `halt_fetch_seq`

## Requirements
- R1: The clock edge that samples `haltExec` high while the block is idle starts the halt. In the next cycle `haltN` is low and fetch state 1 is running. A `haltExec` pulse seen while the block is already halted has no effect.
- R2: Every halted fetch cycle lasts exactly four clock states. In states 1 and 2, `m1N`, `mreqN` and `rdN` are low, `rfshN` is high, and `addrBus` carries the held program counter. In states 3 and 4, `rfshN` and `mreqN` are low, `m1N` and `rdN` are high, and `addrBus` is the refresh register zero-extended.
- R3: While halted, `decodeOp` is 8'h00 (no-operation) whatever `memData` carries. While idle, `decodeOp` follows `memData`.
- R4: On halt entry the held program counter becomes `haltAddr` + 1, modulo 2^ADDR_W. It does not change for the whole halt.
- R5: At the end of each fetch cycle, the low 7 bits of the 8-bit refresh register increase by one and wrap from 127 to 0, while bit 7 keeps its value. `refreshLoad` loads `refreshSeed` only while the block is idle. Reset clears the register.
- R6: Interrupt inputs are sampled only on the clock edge that ends fetch state 4. A request that arrives earlier in the cycle leaves `haltN` low through states 3 and 4. When an exit is taken, `haltN` goes high and `exitValid` pulses in the same following cycle.
- R7: A low `irqN` ends the halt with `exitCause` 2'b01 only if `intEnable` is 1. With `intEnable` at 0 the block starts another fetch cycle.
- R8: A low `nmiN` ends the halt with `exitCause` 2'b10. If both requests are present at the sampling edge, the non-maskable one wins.
- R9: A low `rstN` returns the block to idle at once, without waiting for a clock: `haltN` goes high and all bus strobes go inactive. On the first clock edge after release, `exitValid` is 1 with `exitCause` 2'b11.
- R10: `exitValid` is high for exactly one cycle per event. `exitCause` is 2'b00 whenever `exitValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock state per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| haltExec | input | 1 | Core has executed a halt opcode (one-cycle pulse) |
| haltAddr | input | ADDR_W | Address of the halt opcode |
| refreshLoad | input | 1 | Load the refresh register from `refreshSeed` (idle only) |
| refreshSeed | input | 8 | Value to load into the refresh register |
| intEnable | input | 1 | Maskable interrupts enabled |
| irqN | input | 1 | Maskable interrupt request, active low |
| nmiN | input | 1 | Non-maskable interrupt request, active low |
| memData | input | 8 | Byte returned by memory |
| addrBus | output | ADDR_W | Address bus |
| m1N | output | 1 | Opcode-fetch strobe, active low |
| mreqN | output | 1 | Memory-request strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| haltN | output | 1 | Halt status, active low |
| decodeOp | output | 8 | Opcode passed to the instruction decoder |
| exitValid | output | 1 | One-cycle pulse: the halt has ended |
| exitCause | output | 2 | Cause of the exit: 01 maskable, 10 non-maskable, 11 reset |

## Verification
The bench builds the block with its default 16-bit address bus.

- A halt opcode at 16'hFFFF makes the held program counter wrap to 16'h0000.
- Seeding the refresh register with 8'hFE, with bit 7 set, shows the 7-bit wrap to 8'h80 while bit 7 stays set.
- Requests are raised in fetch state 2, so the bench sees both the added latency and the exit at the cycle boundary.
- Further cases cover maskable interrupts disabled, both requests pending at once, and a reset pulled in the middle of a halt.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  localparam logic [7:0] NOP_CODE = 8'h00;
  localparam int         RFSH_W   = 8;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_IRQ  = 2'b01;
  localparam logic [1:0] CAUSE_NMI  = 2'b10;
  localparam logic [1:0] CAUSE_RST  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic halted;       // inside the halt state
    logic addrFromPc;   // fetch half of the cycle
    logic advanceRfsh;  // last state of a fetch cycle
    logic capturePc;    // halt entry accepted this cycle
  } seqStrobes_t;

endpackage

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
  import halt_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltExec,
  input  logic        intEnable,
  input  logic        irqN,
  input  logic        nmiN,
  output seqStrobes_t strobes,
  output logic        m1N,
  output logic        mreqN,
  output logic        rdN,
  output logic        rfshN,
  output logic        haltN,
  output logic        exitValid,
  output logic [1:0]  exitCause
);

  seqState_e  stateQ, stateD;
  logic       rstSeenQ;
  logic       takeNmi, takeIrq;
  logic       fetchPh, rfshPh;
  logic       exitValidQ;
  logic [1:0] exitCauseQ;

  // exit decisions exist only at the end of fetch state 4
  assign takeNmi = (stateQ == ST_T4) && !nmiN;
  assign takeIrq = (stateQ == ST_T4) && nmiN && !irqN && intEnable;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (haltExec) stateD = ST_T1;
      ST_T1:   stateD = ST_T2;
      ST_T2:   stateD = ST_T3;
      ST_T3:   stateD = ST_T4;
      ST_T4:   stateD = (takeNmi || takeIrq) ? ST_IDLE : ST_T1;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      rstSeenQ   <= 1'b1;
      exitValidQ <= 1'b0;
      exitCauseQ <= CAUSE_NONE;
    end else begin
      stateQ     <= stateD;
      rstSeenQ   <= 1'b0;
      exitValidQ <= takeNmi || takeIrq || rstSeenQ;
      if (takeNmi)       exitCauseQ <= CAUSE_NMI;
      else if (takeIrq)  exitCauseQ <= CAUSE_IRQ;
      else if (rstSeenQ) exitCauseQ <= CAUSE_RST;
      else               exitCauseQ <= CAUSE_NONE;
    end
  end

  assign fetchPh = (stateQ == ST_T1) || (stateQ == ST_T2);
  assign rfshPh  = (stateQ == ST_T3) || (stateQ == ST_T4);

  assign m1N       = !fetchPh;
  assign rdN       = !fetchPh;
  assign mreqN     = !(fetchPh || rfshPh);
  assign rfshN     = !rfshPh;
  assign haltN     = (stateQ == ST_IDLE);
  assign exitValid = exitValidQ;
  assign exitCause = exitCauseQ;

  assign strobes.halted      = (stateQ != ST_IDLE);
  assign strobes.addrFromPc  = fetchPh;
  assign strobes.advanceRfsh = (stateQ == ST_T4);
  assign strobes.capturePc   = (stateQ == ST_IDLE) && haltExec;

  // R6: an interrupt exit only follows fetch state 4
  p_exit_at_boundary_r6: assert property (@(posedge clk) disable iff (!rstN)
    (exitValid && exitCause != CAUSE_RST) |-> ($past(stateQ) == ST_T4));

  // R8: a non-maskable request at the sampling edge always wins
  p_nmi_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T4 && !nmiN) |=> (exitValid && exitCause == CAUSE_NMI && haltN));

  // R7: with maskable interrupts disabled, the halt continues
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T4 && nmiN && !intEnable) |=> (!exitValid && !haltN));

  // R10: the exit report lasts a single cycle
  p_exit_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    exitValid |=> !exitValid);

endmodule

// File: rtl/halt_seq_dp.sv
module halt_seq_dp
  import halt_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   haltAddr,
  input  logic                refreshLoad,
  input  logic [RFSH_W-1:0]   refreshSeed,
  input  logic [7:0]          memData,
  output logic [ADDR_W-1:0]   addrBus,
  output logic [7:0]          decodeOp
);

  localparam int CNT_W = RFSH_W - 1;

  logic [ADDR_W-1:0] pcQ;
  logic [RFSH_W-1:0] rfshQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (strobes.capturePc) begin
      pcQ <= haltAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfshQ <= '0;
    end else if (strobes.advanceRfsh) begin
      rfshQ <= {rfshQ[RFSH_W-1], rfshQ[CNT_W-1:0] + CNT_W'(1)};
    end else if (!strobes.halted && refreshLoad) begin
      rfshQ <= refreshSeed;
    end
  end

  always_comb begin
    if (strobes.halted && !strobes.addrFromPc) addrBus = ADDR_W'(rfshQ);
    else                                        addrBus = pcQ;
  end

  assign decodeOp = strobes.halted ? NOP_CODE : memData;

  // R4: the held program counter does not move during a halt
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.halted && $past(strobes.halted)) |-> $stable(pcQ));

  // R5: the refresh step leaves the top bit alone
  p_rfsh_top_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.advanceRfsh) |-> (rfshQ[RFSH_W-1] == $past(rfshQ[RFSH_W-1])));

endmodule

// File: rtl/halt_fetch_seq.sv
module halt_fetch_seq
  import halt_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltExec,
  input  logic [ADDR_W-1:0] haltAddr,
  input  logic              refreshLoad,
  input  logic [7:0]        refreshSeed,
  input  logic              intEnable,
  input  logic              irqN,
  input  logic              nmiN,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] addrBus,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              rfshN,
  output logic              haltN,
  output logic [7:0]        decodeOp,
  output logic              exitValid,
  output logic [1:0]        exitCause
);

  seqStrobes_t strobes;

  halt_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .haltExec  (haltExec),
    .intEnable (intEnable),
    .irqN      (irqN),
    .nmiN      (nmiN),
    .strobes   (strobes),
    .m1N       (m1N),
    .mreqN     (mreqN),
    .rdN       (rdN),
    .rfshN     (rfshN),
    .haltN     (haltN),
    .exitValid (exitValid),
    .exitCause (exitCause)
  );

  halt_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .haltAddr    (haltAddr),
    .refreshLoad (refreshLoad),
    .refreshSeed (refreshSeed),
    .memData     (memData),
    .addrBus     (addrBus),
    .decodeOp    (decodeOp)
  );

endmodule

// File: tb/halt_fetch_seq_tb_top.sv
module halt_fetch_seq_tb_top;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              haltExec = 1'b0;
  logic [ADDR_W-1:0] haltAddr = '0;
  logic              refreshLoad = 1'b0;
  logic [7:0]        refreshSeed = '0;
  logic              intEnable = 1'b0;
  logic              irqN = 1'b1;
  logic              nmiN = 1'b1;
  logic [7:0]        memData = '0;
  logic [ADDR_W-1:0] addrBus;
  logic              m1N, mreqN, rdN, rfshN, haltN, exitValid;
  logic [7:0]        decodeOp;
  logic [1:0]        exitCause;

  int  vecs = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [7:0]        expRfsh;
  logic [ADDR_W-1:0] expPc;

  always #5 clk = ~clk;

  halt_fetch_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .haltExec(haltExec), .haltAddr(haltAddr),
    .refreshLoad(refreshLoad), .refreshSeed(refreshSeed), .intEnable(intEnable),
    .irqN(irqN), .nmiN(nmiN), .memData(memData), .addrBus(addrBus),
    .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .rfshN(rfshN), .haltN(haltN),
    .decodeOp(decodeOp), .exitValid(exitValid), .exitCause(exitCause)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [3:0]  extra;   // fetch cycles before the request
    logic        nmiAct;
    logic        irqAct;
    logic        ie;
    logic [1:0]  cause;   // 00 = stays halted
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h1233, 4'd0, 1'b0, 1'b1, 1'b1, 2'b01},
    '{16'h4000, 4'd2, 1'b1, 1'b0, 1'b0, 2'b10},
    '{16'hFFFF, 4'd1, 1'b1, 1'b1, 1'b1, 2'b10},
    '{16'h00FF, 4'd0, 1'b0, 1'b1, 1'b0, 2'b00},
    '{16'h7FFE, 4'd3, 1'b0, 1'b1, 1'b1, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // entered at the negedge inside fetch state 1; leaves at the negedge after state 4
  task automatic fetchCycle(input bit raiseEvt, input bit nmiV, input bit irqV);
    memData = 8'h76;
    chk("R2 state1 strobes", {m1N, mreqN, rdN, rfshN, haltN}, 5'b00010);
    chk("R4 state1 address", addrBus, expPc);
    chk("R3 forced nop", decodeOp, 8'h00);
    haltExec = 1'b0;
    @(negedge clk);
    chk("R2 state2 strobes", {m1N, mreqN, rdN, rfshN, haltN}, 5'b00010);
    chk("R4 state2 address", addrBus, expPc);
    memData = 8'hC3;
    #1 chk("R3 data ignored", decodeOp, 8'h00);
    if (raiseEvt) begin
      nmiN = !nmiV;
      irqN = !irqV;
    end
    @(negedge clk);
    chk("R2 state3 strobes", {m1N, mreqN, rdN, rfshN}, 4'b1010);
    chk("R6 held through state3", haltN, 1'b0);
    chk("R5 refresh address", addrBus, {8'h00, expRfsh});
    @(negedge clk);
    chk("R2 state4 strobes", {m1N, mreqN, rdN, rfshN}, 4'b1010);
    chk("R6 held through state4", haltN, 1'b0);
    chk("R5 refresh address", addrBus, {8'h00, expRfsh});
    expRfsh = {expRfsh[7], expRfsh[6:0] + 7'd1};
    @(negedge clk);
  endtask

  task automatic checkExit(input logic [1:0] cause, input string req);
    chk({req, " exit halt line"}, haltN, 1'b1);
    chk({req, " exit valid"}, exitValid, 1'b1);
    chk({req, " exit cause"}, exitCause, cause);
    nmiN = 1'b1;
    irqN = 1'b1;
    @(negedge clk);
    chk("R10 single pulse", {exitValid, exitCause}, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state, then one reset report
    @(negedge clk);
    chk("R9 reset idle", {haltN, m1N, mreqN, rdN, rfshN, exitValid}, 6'b111110);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset report", {exitValid, exitCause}, 3'b111);
    @(negedge clk);
    chk("R10 reset report ends", {exitValid, exitCause}, 3'b000);

    // R3: pass-through while idle
    memData = 8'h5A;
    #1 chk("R3 idle passthrough", decodeOp, 8'h5A);

    // R5: seed the refresh register near the 7-bit wrap
    refreshLoad = 1'b1;
    refreshSeed = 8'hFE;
    @(negedge clk);
    refreshLoad = 1'b0;
    expRfsh = 8'hFE;

    foreach (VECS[i]) begin
      intEnable = VECS[i].ie;
      haltAddr  = VECS[i].addr;
      haltExec  = 1'b1;
      @(negedge clk);
      haltExec = 1'b0;
      expPc = VECS[i].addr + 16'd1;
      chk("R1 halt entry", haltN, 1'b0);
      for (int k = 0; k < int'(VECS[i].extra); k++) fetchCycle(1'b0, 1'b0, 1'b0);
      fetchCycle(1'b1, VECS[i].nmiAct, VECS[i].irqAct);
      if (VECS[i].cause != 2'b00) begin
        checkExit(VECS[i].cause, VECS[i].nmiAct ? "R8" : "R7");
      end else begin
        chk("R7 disabled irq keeps halt", {haltN, exitValid, m1N}, 3'b000);
        haltAddr = 16'h9999;
        haltExec = 1'b1;   // R1: ignored while halted
        fetchCycle(1'b1, 1'b1, 1'b1);
        checkExit(2'b10, "R8");
      end
    end

    // R9: reset in the middle of a halt acts at once
    refreshLoad = 1'b1;
    refreshSeed = 8'h10;
    @(negedge clk);
    refreshLoad = 1'b0;
    haltAddr = 16'h2000;
    haltExec = 1'b1;
    @(negedge clk);
    haltExec = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1 chk("R9 async reset", {haltN, m1N, mreqN, rdN, rfshN}, 5'b11111);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset report", {exitValid, exitCause}, 3'b111);
    @(negedge clk);
    expRfsh = 8'h00;   // R5: reset clears refresh
    haltAddr = 16'h3000;
    haltExec = 1'b1;
    @(negedge clk);
    expPc = 16'h3001;
    fetchCycle(1'b1, 1'b1, 1'b0);
    checkExit(2'b10, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule